// File: doc/BRIEF.md
# Addressable Latch with Demultiplexer Mode

An eight-output storage element addressed one bit at a time. A 3-bit select, a single data bit, an active-low enable and an active-low clear together pick one of four operating modes. The block can work as a bank of individually writable bits, as a frozen register, as a one-of-eight demultiplexer, or as a cleared output port.

The stored bits live in a clocked register bank that updates on the rising edge of `clk`. The outputs come from a combinational path that reads the bank, the select and the data bit. As a result, a written bit is visible on its output in the same cycle it is written. The demultiplexer mode drives the outputs straight from the decode, and the bank is cleared while that mode is active. Callers change the select only while in hold mode. Moving several select bits at once while writing could briefly target the wrong bit.

Top module: `addr_latch_demux`

## Requirements
- R1: While `rst_n` is low, the bank is cleared asynchronously. After reset is released in hold mode, `q` reads 0.
- R2: In write mode (`clr_n`=1, `en_n`=0), the bit picked by `sel_addr` takes the value of `din` at the rising edge. Every other bit keeps its value, and the result reads back in later hold cycles.
- R3: In write mode, `q` shows the stored bits, except that the selected bit is replaced by `din` in the same cycle.
- R4: In hold mode (`clr_n`=1, `en_n`=1), `q` shows the stored bits unchanged, and `sel_addr` and `din` have no effect.
- R5: In demultiplexer mode (`clr_n`=0, `en_n`=0), the selected output equals `din` and every other output is 0, within the same cycle.
- R6: The demultiplexer mode clears the bank at the rising edge, so a following hold cycle shows all zeros.
- R7: In clear mode (`clr_n`=0, `en_n`=1), `q` is 0 whatever `sel_addr` and `din` are, and the bank is cleared at the rising edge.
- R8: The select is a binary number with bit 2 as its most significant bit. Value 0 picks `q[0]` and value 7 picks `q[7]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bank updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the bank |
| sel_addr | input | 3 | Binary select of one output |
| din | input | 1 | Data bit |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| q | output | 8 | Output bits |

## Verification
The mode-dependent view on `q` (R3, R4, R5, R7, R8) is due in the same cycle as the stimulus. The bench therefore drives inputs at the falling edge and compares `q` two nanoseconds later, before the next rising edge. A write, or the clearing by the demultiplexer and clear modes (R2, R6, R7), takes effect at the next rising edge. It is first seen in the cycle after that, when the reference model has been updated at the same edge. The bench also counts select changes made between two consecutive write cycles, as a protocol check on its own stimulus.

// File: rtl/addr_latch_demux.sv
module addr_latch_demux #(
  parameter int NUM_OUTS = 8,
  localparam int AW = $clog2(NUM_OUTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       sel_addr,
  input  logic                din,
  input  logic                en_n,
  input  logic                clr_n,
  output logic [NUM_OUTS-1:0] q
);

  logic [NUM_OUTS-1:0] store;
  logic [NUM_OUTS-1:0] sel_hot;
  logic [NUM_OUTS-1:0] data_rep;
  logic [NUM_OUTS-1:0] wr_val;

  assign sel_hot  = {{(NUM_OUTS-1){1'b0}}, 1'b1} << sel_addr;
  assign data_rep = {NUM_OUTS{din}};
  assign wr_val   = (store & ~sel_hot) | (sel_hot & data_rep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     store <= '0;
    else if (!clr_n) store <= '0;
    else if (!en_n)  store <= wr_val;
  end

  always_comb begin
    unique case ({clr_n, en_n})
      2'b10:   q = wr_val;
      2'b11:   q = store;
      2'b00:   q = sel_hot & data_rep;
      default: q = '0;
    endcase
  end

endmodule

// File: rtl/addr_latch_demux_chk.sv
module addr_latch_demux_chk #(
  parameter int NUM_OUTS = 8,
  localparam int AW = $clog2(NUM_OUTS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [AW-1:0]       sel_addr,
  input logic                din,
  input logic                en_n,
  input logic                clr_n,
  input logic [NUM_OUTS-1:0] q
);

  assert_latch_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_n && !en_n) && $past(rst_n) && clr_n && en_n) |-> q == $past(q));

  assert_latch_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !en_n) |-> q[sel_addr] == din);

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && en_n && $past(clr_n && en_n) && $past(rst_n)) |-> $stable(q));

  assert_demux_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !en_n) |-> ($countones(q) <= 1 && q[sel_addr] == din));

  assert_demux_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!clr_n) && $past(rst_n) && clr_n && en_n) |-> q == '0);

  assert_clear_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && en_n) |-> q == '0);

endmodule

bind addr_latch_demux addr_latch_demux_chk #(.NUM_OUTS(NUM_OUTS)) u_chk (.*);

// File: tb/addr_latch_demux_bench.sv
module addr_latch_demux_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] sel_addr = '0;
  logic       din = 0;
  logic       en_n = 1;
  logic       clr_n = 1;
  logic [7:0] q;

  int checks = 0, errors = 0, viol = 0;
  bit model[8];
  bit prev_write = 0;
  logic [2:0] prev_addr = '0;

  always #4 clk = ~clk;

  addr_latch_demux u_addr_latch_demux (.*);

  function automatic logic [7:0] expect_q(logic [2:0] a, logic d, logic en, logic clr);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (!clr && en)        r[i] = 1'b0;
      else if (!clr)         r[i] = (i == a) ? d : 1'b0;
      else if (!en)          r[i] = (i == a) ? d : model[i];
      else                   r[i] = model[i];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [2:0] a, logic d, logic en, logic clr, logic rst);
    @(negedge clk);
    sel_addr = a; din = d; en_n = en; clr_n = clr; rst_n = rst;
    if (clr && !en && prev_write && a != prev_addr) viol++;
    prev_write = clr && !en;
    prev_addr = a;
    #2;
    if (rst) check(tag, q, expect_q(a, d, en, clr));
    else for (int i = 0; i < 8; i++) model[i] = 0;
    @(posedge clk);
    if (!rst || !clr) for (int i = 0; i < 8; i++) model[i] = 0;
    else if (!en) model[a] = d;
  endtask

  task automatic write_bit(logic [2:0] a, logic d);
    step("R4", a, ~d, 1, 1, 1);
    step("R3", a, d, 0, 1, 1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (2) step("R1", 3'd5, 1, 0, 1, 0);
    step("R1", 3'd0, 0, 1, 1, 1);
    check("R1", q, 8'h00);
    // R2: write pattern 0xA5 bit by bit, then read back in hold
    for (int i = 0; i < 8; i++) write_bit(3'(i), 1'((8'hA5 >> i) & 1));
    step("R2", 3'd3, 1, 1, 1, 1);
    check("R2", q, 8'hA5);
    // R4: hold ignores select and data
    for (int i = 0; i < 8; i++) step("R4", 3'(7 - i), 1'(i & 1), 1, 1, 1);
    check("R4", q, 8'hA5);
    // R2: overwrite one bit, others keep
    write_bit(3'd2, 0);
    write_bit(3'd6, 1);
    step("R2", 3'd0, 0, 1, 1, 1);
    check("R2", q, 8'hE1);
    // R5 / R8: demultiplexer over all selects and both data values
    for (int i = 0; i < 8; i++) begin
      step("R5", 3'(i), 1, 0, 0, 1);
      step("R5", 3'(i), 0, 0, 0, 1);
    end
    step("R8", 3'd0, 1, 0, 0, 1);
    check("R8", q, 8'h01);
    step("R8", 3'd7, 1, 0, 0, 1);
    check("R8", q, 8'h80);
    step("R6", 3'd7, 1, 1, 1, 1);
    check("R6", q, 8'h00);
    // R7: clear mode
    for (int i = 0; i < 8; i++) write_bit(3'(i), 1);
    step("R2", 3'd1, 0, 1, 1, 1);
    check("R2", q, 8'hFF);
    step("R7", 3'd4, 1, 1, 0, 1);
    check("R7", q, 8'h00);
    step("R7", 3'd1, 0, 1, 1, 1);
    check("R7", q, 8'h00);
    // R1: reset in the middle of a run
    write_bit(3'd5, 1);
    step("R1", 3'd5, 1, 1, 1, 0);
    step("R1", 3'd5, 1, 1, 1, 1);
    check("R1", q, 8'h00);
    checks++;
    if (viol != 0) begin
      errors++;
      $display("FAIL R2: select changed during write %0d times, expected 0", viol);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule